// File: doc/BRIEF.md
# Seconds Counter with Trim Prescaler

This block keeps a free-running count of elapsed seconds. All of its counting logic runs on a slow clock of about 32 kHz. That clock keeps running when the bus side is idle or powered down, so the count stays valid across bus sleep. A programmable trim value divides the slow clock down to a tick, and each tick advances a 32-bit count by one. A trim of 32767 on a 32.768 kHz clock gives one tick per second.

Software reaches the block through four word registers clocked by a faster bus clock:

- a trim register;
- a load register that presets the count;
- a read register that returns a coherent copy of the count;
- a control/status register.

Trim and load writes cross into the slow domain through a toggle handshake. Each of these writes raises a sticky pending flag. The flag drops only after the slow domain has taken the value, which can take seconds on real hardware. Software must poll the flag before it writes the same register again. The status register also reports whether the slow clock is present, which is judged against a bus-clock timeout.

Top module: `toy_seconds_counter`

## Requirements
- R1: After reset the count reads 0, the trim readback is 0, the enable bit is 0 and both pending flags are 0.
- R2: While enabled, the count advances by exactly one every trim+1 slow-clock cycles, and never by more than one per slow cycle.
- R3: While the enable bit is 0, the count holds its value.
- R4: A write to the load register (address 1) sets the count-pending flag (status bit 2) on the next bus cycle. The flag clears once the slow domain has loaded the value, after which the count reads the written value.
- R5: A write to the trim register (address 0) sets the trim-pending flag (status bit 3) on the next bus cycle. The flag clears once the slow domain has taken the new trim, and the trim readback at address 0 returns the accepted value.
- R6: A write to the trim or load register while that register's pending flag is set is ignored.
- R7: The count wraps from 0xFFFFFFFF to 0.
- R8: Reads of the count register (address 2) never return a torn value. Successive reads never go backwards and never jump by more than a few ticks.
- R9: The clock-present flag (status bit 1) is set while the slow clock toggles within DET_TIMEOUT bus cycles. It clears when no slow edge is seen for DET_TIMEOUT bus cycles.
- R10: The control/status register (address 3) holds enable in bit 0, written from write data bit 0. Its other bits are read-only status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Bus-side clock |
| slow_clk | input | 1 | Slow counting clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| reg_wr | input | 1 | Register write strobe, one bus cycle |
| reg_addr | input | 2 | Register select: 0 trim, 1 load, 2 count, 3 control/status |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for the selected register |

## Verification
The bench attacks the second write issued while a handshake is still open. A design that fails to block it would overwrite the held data while the slow side samples it, and the trim or count would end up at the second value.

The bench measures the tick rate over forty ticks at a small trim. An off-by-one prescaler would drift by about a tick every four.

It loads 0xFFFFFFFF and enables counting to catch a counter that saturates or sticks instead of wrapping. It also polls the count on every bus cycle while counting at full speed, where a torn or unsynchronised copy would show backward steps or wild jumps.

The bench stops the slow clock to check that the clock-present flag falls rather than latching high.

// File: rtl/toy_pkg.sv
package toy_pkg;
   typedef enum logic [1:0] {
      SEL_TRIM  = 2'd0,
      SEL_LOAD  = 2'd1,
      SEL_COUNT = 2'd2,
      SEL_CTRL  = 2'd3
   } reg_sel_e;

   localparam int ST_EN    = 0;
   localparam int ST_CLKOK = 1;
   localparam int ST_CPEND = 2;
   localparam int ST_TPEND = 3;
endpackage

// File: rtl/toy_sync.sv
module toy_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("toy_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/toy_xfer.sv
// Bus-to-slow word transfer: toggle request, toggle acknowledge, sticky pending.
module toy_xfer #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         bus_clk,
   input  logic         slow_clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   output logic         pending,
   output logic [W-1:0] held,
   output logic         load
);
   logic req_t, ack_t, req_s, ack_s;

   // bus side: accept only when idle, hold data until acknowledged
   always_ff @(posedge bus_clk or negedge rst_n) begin
      if (!rst_n) begin
         req_t <= 1'b0;
         held  <= '0;
      end else if (wr_en && !pending) begin
         req_t <= ~req_t;
         held  <= wr_data;
      end
   end

   assign pending = req_t ^ ack_s;

   toy_sync #(.STAGES(STAGES)) u_req_sync (
      .clk(slow_clk), .rst_n(rst_n), .d(req_t), .q(req_s));

   // slow side: one-cycle load on each request edge
   always_ff @(posedge slow_clk or negedge rst_n) begin
      if (!rst_n) ack_t <= 1'b0;
      else        ack_t <= req_s;
   end

   assign load = req_s ^ ack_t;

   toy_sync #(.STAGES(STAGES)) u_ack_sync (
      .clk(bus_clk), .rst_n(rst_n), .d(ack_t), .q(ack_s));
endmodule

// File: rtl/toy_snap.sv
// Slow-to-bus coherent copy of a word through a repeating toggle handshake.
module toy_snap #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         bus_clk,
   input  logic         slow_clk,
   input  logic         rst_n,
   input  logic [W-1:0] src,
   output logic [W-1:0] copy
);
   logic         req_t, req_s, ack_t, ack_s;
   logic [W-1:0] snap;

   toy_sync #(.STAGES(STAGES)) u_req_sync (
      .clk(slow_clk), .rst_n(rst_n), .d(req_t), .q(req_s));

   always_ff @(posedge slow_clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_t <= 1'b0;
         snap  <= '0;
      end else begin
         ack_t <= req_s;
         if (req_s ^ ack_t) snap <= src;
      end
   end

   toy_sync #(.STAGES(STAGES)) u_ack_sync (
      .clk(bus_clk), .rst_n(rst_n), .d(ack_t), .q(ack_s));

   // snap is frozen while the acknowledge matches the request
   always_ff @(posedge bus_clk or negedge rst_n) begin
      if (!rst_n) begin
         req_t <= 1'b0;
         copy  <= '0;
      end else if (ack_s == req_t) begin
         copy  <= snap;
         req_t <= ~req_t;
      end
   end
endmodule

// File: rtl/toy_core.sv
// Slow-domain prescaler and seconds counter.
module toy_core #(
   parameter int CNT_W  = 32,
   parameter int TRIM_W = 16
) (
   input  logic              slow_clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              trim_load,
   input  logic [TRIM_W-1:0] trim_data,
   input  logic              cnt_load,
   input  logic [CNT_W-1:0]  cnt_data,
   output logic [CNT_W-1:0]  cnt
);
   logic [TRIM_W-1:0] trim_q;
   logic [TRIM_W-1:0] presc;
   logic              tick;

   // a trim shrunk below the running phase ends the period at once
   assign tick = en && (presc >= trim_q);

   always_ff @(posedge slow_clk or negedge rst_n) begin
      if (!rst_n)         trim_q <= '0;
      else if (trim_load) trim_q <= trim_data;
   end

   always_ff @(posedge slow_clk or negedge rst_n) begin
      if (!rst_n) begin
         presc <= '0;
         cnt   <= '0;
      end else if (cnt_load) begin
         presc <= '0;
         cnt   <= cnt_data;
      end else if (tick) begin
         presc <= '0;
         cnt   <= cnt + 1'b1;
      end else if (en) begin
         presc <= presc + 1'b1;
      end
   end
endmodule

// File: rtl/toy_clkdet.sv
// Bus-domain watchdog on the slow clock.
module toy_clkdet #(
   parameter int TIMEOUT = 64,
   parameter int STAGES  = 2
) (
   input  logic bus_clk,
   input  logic rst_n,
   input  logic slow_clk,
   output logic clk_ok
);
   localparam int AW = $clog2(TIMEOUT + 1);
   localparam logic [AW-1:0] LIMIT = AW'(TIMEOUT - 1);

   logic          s, s_d;
   logic [AW-1:0] age;

   toy_sync #(.STAGES(STAGES)) u_sync (
      .clk(bus_clk), .rst_n(rst_n), .d(slow_clk), .q(s));

   always_ff @(posedge bus_clk or negedge rst_n) begin
      if (!rst_n) begin
         s_d    <= 1'b0;
         age    <= '0;
         clk_ok <= 1'b0;
      end else begin
         s_d <= s;
         if (s ^ s_d) begin
            age    <= '0;
            clk_ok <= 1'b1;
         end else if (age != LIMIT) begin
            age <= age + 1'b1;
         end else begin
            clk_ok <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/toy_seconds_counter.sv
module toy_seconds_counter #(
   parameter int CNT_W       = 32,
   parameter int TRIM_W      = 16,
   parameter int SYNC_STAGES = 2,
   parameter int DET_TIMEOUT = 64,
   parameter bit DET_ENABLE  = 1'b1
) (
   input  logic             bus_clk,
   input  logic             slow_clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [1:0]       reg_addr,
   input  logic [CNT_W-1:0] reg_wdata,
   output logic [CNT_W-1:0] reg_rdata
);
   import toy_pkg::*;

   if (CNT_W < 8 || TRIM_W < 1 || TRIM_W > CNT_W - 4) begin : g_bad_width
      $error("toy_seconds_counter: width parameters out of range");
   end
   if (DET_TIMEOUT < 8) begin : g_bad_timeout
      $error("toy_seconds_counter: DET_TIMEOUT too small");
   end

   reg_sel_e          sel;
   logic              en_bus, en_slow, clk_ok;
   logic              tpend, cpend, trim_load, cnt_load;
   logic [TRIM_W-1:0] trim_hold;
   logic [CNT_W-1:0]  cnt_data, cnt_q, cnt_copy;
   logic              unused_wdata_hi;

   assign sel             = reg_sel_e'(reg_addr);
   assign unused_wdata_hi = ^reg_wdata[CNT_W-1:TRIM_W];

   always_ff @(posedge bus_clk or negedge rst_n) begin
      if (!rst_n)                          en_bus <= 1'b0;
      else if (reg_wr && sel == SEL_CTRL)  en_bus <= reg_wdata[0];
   end

   toy_xfer #(.W(TRIM_W), .STAGES(SYNC_STAGES)) u_trim_xfer (
      .bus_clk(bus_clk), .slow_clk(slow_clk), .rst_n(rst_n),
      .wr_en(reg_wr && sel == SEL_TRIM), .wr_data(reg_wdata[TRIM_W-1:0]),
      .pending(tpend), .held(trim_hold), .load(trim_load));

   toy_xfer #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_cnt_xfer (
      .bus_clk(bus_clk), .slow_clk(slow_clk), .rst_n(rst_n),
      .wr_en(reg_wr && sel == SEL_LOAD), .wr_data(reg_wdata),
      .pending(cpend), .held(cnt_data), .load(cnt_load));

   toy_sync #(.STAGES(SYNC_STAGES)) u_en_sync (
      .clk(slow_clk), .rst_n(rst_n), .d(en_bus), .q(en_slow));

   toy_core #(.CNT_W(CNT_W), .TRIM_W(TRIM_W)) u_core (
      .slow_clk(slow_clk), .rst_n(rst_n), .en(en_slow),
      .trim_load(trim_load), .trim_data(trim_hold),
      .cnt_load(cnt_load), .cnt_data(cnt_data), .cnt(cnt_q));

   toy_snap #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_snap (
      .bus_clk(bus_clk), .slow_clk(slow_clk), .rst_n(rst_n),
      .src(cnt_q), .copy(cnt_copy));

   if (DET_ENABLE) begin : g_det
      toy_clkdet #(.TIMEOUT(DET_TIMEOUT), .STAGES(SYNC_STAGES)) u_det (
         .bus_clk(bus_clk), .rst_n(rst_n), .slow_clk(slow_clk),
         .clk_ok(clk_ok));
   end else begin : g_nodet
      assign clk_ok = 1'b1;
   end

   always_comb begin
      reg_rdata = '0;
      unique case (sel)
         SEL_TRIM:  reg_rdata[TRIM_W-1:0] = trim_hold;
         SEL_LOAD:  reg_rdata = cnt_data;
         SEL_COUNT: reg_rdata = cnt_copy;
         SEL_CTRL: begin
            reg_rdata[ST_EN]    = en_bus;
            reg_rdata[ST_CLKOK] = clk_ok;
            reg_rdata[ST_CPEND] = cpend;
            reg_rdata[ST_TPEND] = tpend;
         end
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/toy_seconds_counter_chk.sv
module toy_seconds_counter_chk #(
   parameter int CNT_W  = 32,
   parameter int TRIM_W = 16
) (
   input logic              bus_clk,
   input logic              slow_clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [1:0]        reg_addr,
   input logic              tpend,
   input logic              cpend,
   input logic [TRIM_W-1:0] trim_hold,
   input logic [CNT_W-1:0]  cnt_data,
   input logic              cnt_load,
   input logic              en_slow,
   input logic [CNT_W-1:0]  cnt_q
);
   p_cnt_pend_set_r4: assert property (@(posedge bus_clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd1 && !cpend) |=> cpend);

   p_trim_pend_set_r5: assert property (@(posedge bus_clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd0 && !tpend) |=> tpend);

   p_trim_ignored_r6: assert property (@(posedge bus_clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd0 && tpend) |=> $stable(trim_hold));

   p_load_ignored_r6: assert property (@(posedge bus_clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd1 && cpend) |=> $stable(cnt_data));

   p_hold_off_r3: assert property (@(posedge slow_clk) disable iff (!rst_n)
      (!cnt_load && !en_slow) |=> $stable(cnt_q));

   p_single_step_r2: assert property (@(posedge slow_clk) disable iff (!rst_n)
      !cnt_load |=> (cnt_q == $past(cnt_q)) || (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

   p_load_value_r4: assert property (@(posedge slow_clk) disable iff (!rst_n)
      cnt_load |=> cnt_q == $past(cnt_data));
endmodule

bind toy_seconds_counter toy_seconds_counter_chk #(.CNT_W(CNT_W), .TRIM_W(TRIM_W)) u_chk (
   .bus_clk(bus_clk), .slow_clk(slow_clk), .rst_n(rst_n),
   .reg_wr(reg_wr), .reg_addr(reg_addr), .tpend(tpend), .cpend(cpend),
   .trim_hold(trim_hold), .cnt_data(cnt_data), .cnt_load(cnt_load),
   .en_slow(en_slow), .cnt_q(cnt_q));

// File: tb/toy_seconds_counter_bench.sv
module toy_seconds_counter_bench;
   localparam int CLK_PERIOD = 10;
   localparam int SLOW_HALF  = 40;
   localparam int SLOW_CYC   = 2 * SLOW_HALF / CLK_PERIOD;

   logic        bus_clk = 1'b0;
   logic        slow_clk = 1'b0;
   logic        slow_run = 1'b1;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   toy_seconds_counter u_toy_seconds_counter (
      .bus_clk(bus_clk), .slow_clk(slow_clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata));

   always #(CLK_PERIOD / 2) bus_clk = ~bus_clk;
   initial forever begin
      #(SLOW_HALF);
      if (slow_run) slow_clk = ~slow_clk;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_range(input string req, input logic [31:0] act,
                              input logic [31:0] lo, input logic [31:0] hi);
      n_tests++;
      if (act < lo || act > hi) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h..%h", req, act, lo, hi);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge bus_clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge bus_clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge bus_clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_clear(input int bitpos, output bit ok);
      logic [31:0] s;
      ok = 1'b0;
      for (int i = 0; i < 400; i++) begin
         rd(2'd3, s);
         if (!s[bitpos]) begin ok = 1'b1; break; end
         @(negedge bus_clk);
      end
   endtask

   task automatic t_reset;
      logic [31:0] v;
      idle(4 * SLOW_CYC);
      rd(2'd2, v); check("R1 count", v, 32'd0);
      rd(2'd0, v); check("R1 trim", v, 32'd0);
      rd(2'd3, v); check("R1 en/pending", v & 32'hD, 32'd0);
   endtask

   task automatic t_clkdet;
      logic [31:0] v;
      idle(20);
      rd(2'd3, v); check("R9 detected", {31'd0, v[1]}, 32'd1);
      slow_run = 1'b0;
      idle(100);
      rd(2'd3, v); check("R9 lost", {31'd0, v[1]}, 32'd0);
      slow_run = 1'b1;
      idle(20);
      rd(2'd3, v); check("R9 back", {31'd0, v[1]}, 32'd1);
   endtask

   task automatic t_trim;
      logic [31:0] v;
      bit ok;
      wr(2'd0, 32'd3);
      rd(2'd3, v); check("R5 trim pending set", {31'd0, v[3]}, 32'd1);
      wr(2'd0, 32'd9);
      rd(2'd0, v); check("R6 trim write ignored", v, 32'd3);
      wait_clear(3, ok);
      check("R5 trim pending clears", {31'd0, ok}, 32'd1);
      rd(2'd0, v); check("R5 trim readback", v, 32'd3);
   endtask

   task automatic t_load;
      logic [31:0] v;
      bit ok;
      wr(2'd1, 32'd100);
      rd(2'd3, v); check("R4 load pending set", {31'd0, v[2]}, 32'd1);
      wr(2'd1, 32'd5);
      wait_clear(2, ok);
      check("R4 load pending clears", {31'd0, ok}, 32'd1);
      idle(6 * SLOW_CYC);
      rd(2'd2, v); check("R4/R6 loaded value", v, 32'd100);
   endtask

   task automatic t_disabled;
      logic [31:0] v;
      idle(40 * SLOW_CYC);
      rd(2'd2, v); check("R3 hold while disabled", v, 32'd100);
   endtask

   task automatic t_rate;
      logic [31:0] a, b;
      wr(2'd3, 32'd1);
      rd(2'd3, a); check("R10 enable readback", a & 32'h1, 32'd1);
      idle(10 * SLOW_CYC);
      rd(2'd2, a);
      idle(160 * SLOW_CYC);
      rd(2'd2, b);
      check_range("R2 tick rate trim=3", b - a, 32'd39, 32'd41);
   endtask

   task automatic t_wrap;
      logic [31:0] v;
      bit ok;
      wr(2'd3, 32'd0);
      wr(2'd0, 32'd0);
      wait_clear(3, ok);
      wr(2'd1, 32'hFFFF_FFFF);
      wait_clear(2, ok);
      idle(6 * SLOW_CYC);
      rd(2'd2, v); check("R7 preset max", v, 32'hFFFF_FFFF);
      wr(2'd3, 32'd1);
      idle(10 * SLOW_CYC);
      rd(2'd2, v); check_range("R7 wrapped to small", v, 32'd1, 32'd12);
   endtask

   task automatic t_coherent;
      logic [31:0] prev, v;
      int bad = 0;
      rd(2'd2, prev);
      for (int i = 0; i < 300; i++) begin
         @(negedge bus_clk);
         rd(2'd2, v);
         if (v < prev || v - prev > 32'd8) bad++;
         prev = v;
      end
      check("R8 coherent monotonic reads", bad, 32'd0);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      t_reset;
      t_clkdet;
      t_trim;
      t_load;
      t_disabled;
      t_rate;
      t_wrap;
      t_coherent;
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150000) @(posedge bus_clk);
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=running expected=done");
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule